// File: doc/BRIEF.md
# Monochrome Raster Timing Generator

This block produces every timing signal needed to scan a 512 by 342 display holding one bit per pixel, driven from a single dot clock. A horizontal counter steps once per dot and a vertical counter steps once per line. From these two counters the block decodes four active-low blank and sync strobes and an active-high flag that marks visible pixels. It also produces a one-clock pulse once per frame that marks the entry into vertical blanking.

The same counters drive a byte address into a frame buffer that sits in shared main memory. Each byte holds eight pixels. The address walks through the buffer in raster order during visible dots and holds still while the beam is blanked. A pixel fetch unit elsewhere uses this address and the active flag to read and serialize the picture. This block does no memory access itself.

All geometry figures are parameters. The defaults are as follows:

- Lines are 704 dots long: 512 visible dots, a 14-dot front porch, then a 178-dot sync.
- Frames are 370 lines long: 342 visible lines with no front porch, 4 sync lines, then 24 lines of back porch.
- The frame buffer base is byte address 0x9F9A80.

Top module: `mono_raster_timing`

## Requirements
- R1: On a clock edge with `rst` high, the block returns to dot 0 of line 0. The first following cycle then shows `active`=1, `fb_addr`=FB_BASE, `frame_irq`=0, and `hblank_n`, `hsync_n`, `vblank_n`, `vsync_n` all 1.
- R2: A line lasts H_ACTIVE+H_BLANK dot clocks (704 by default). `hblank_n` is 0 exactly on dots H_ACTIVE through the last dot of the line (dots 512 to 703 by default).
- R3: `hsync_n` is 0 for H_SYNC dots. It starts on dot H_ACTIVE+H_FP, right after the front porch (dots 526 to 703 by default, so the default back porch is 0 dots). It is low only while `hblank_n` is 0.
- R4: A frame lasts V_ACTIVE+V_BLANK lines (370 by default). `vblank_n` is 0 exactly on lines V_ACTIVE through the last line (lines 342 to 369 by default).
- R5: `vsync_n` is 0 for V_SYNC lines, starting on line V_ACTIVE+V_FP. By default this is lines 342 to 345: the front porch is zero lines and the back porch is 24 lines. It is low only while `vblank_n` is 0.
- R6: `active` is 1 exactly when both the dot number is below H_ACTIVE and the line number is below V_ACTIVE.
- R7: On visible dot h of visible line v, `fb_addr` equals FB_BASE + v*(H_ACTIVE/8) + h/8. That is, the address rises by one after every eighth visible dot.
- R8: `fb_addr` does not change while `active` is 0, except at the wrap from the last dot of a frame, where it returns to FB_BASE. During horizontal blanking of line v it holds FB_BASE+(v+1)*(H_ACTIVE/8). During vertical blanking it holds FB_BASE + H_ACTIVE*V_ACTIVE/8, which is 0x9FF000 by default.
- R9: `frame_irq` is 1 for exactly one dot clock per frame, on dot 0 of line V_ACTIVE: the first cycle of vertical blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| hblank_n | output | 1 | Horizontal blank, low outside visible dots |
| hsync_n | output | 1 | Horizontal sync, active low |
| vblank_n | output | 1 | Vertical blank, low outside visible lines |
| vsync_n | output | 1 | Vertical sync, active low |
| active | output | 1 | High on visible pixels |
| fb_addr | output | ADDR_W | Frame buffer byte address for the current eight-pixel group |
| frame_irq | output | 1 | One-clock pulse at the start of vertical blanking |

## Verification
Every output is a pure function of the two counters and the address register. A dot counter that skips or repeats a value therefore moves the blank and sync edges in the same cycle, and it shifts every later line. A line counter error becomes visible on the next line boundary through the vertical strobes and `frame_irq`. An address register that drifts shows on `fb_addr` on the very next visible byte, and it stays wrong for the rest of the frame, so a per-clock comparison with a behavioural model catches it at once. The full default frame is too long for a short run. The default geometry is therefore compared over its first lines, and a reduced geometry that uses the same code paths is compared across several whole frames and a mid-frame reset.

// File: rtl/mrt_pkg.sv
package mrt_pkg;
   // Default geometry of the display
   localparam int unsigned DEF_H_ACTIVE = 512;
   localparam int unsigned DEF_H_BLANK  = 192;
   localparam int unsigned DEF_H_FP     = 14;
   localparam int unsigned DEF_H_SYNC   = 178;
   localparam int unsigned DEF_V_ACTIVE = 342;
   localparam int unsigned DEF_V_BLANK  = 28;
   localparam int unsigned DEF_V_FP     = 0;
   localparam int unsigned DEF_V_SYNC   = 4;
   localparam int unsigned DEF_ADDR_W   = 24;
   localparam int unsigned DEF_PIX_BYTE = 8;

   // Decoded strobes for one scan axis
   typedef struct packed {
      logic visible;
      logic blank_n;
      logic sync_n;
   } axis_strobe_t;
endpackage

// File: rtl/mrt_axis_counter.sv
module mrt_axis_counter #(
   parameter int unsigned TOTAL = 704,
   parameter int unsigned CW    = $clog2(TOTAL)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          adv,
   output logic [CW-1:0] cnt,
   output logic          wrap
);
   localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

   initial begin
      assert (TOTAL >= 2) else $error("counter total too small");
      assert ((1 << CW) >= TOTAL) else $error("counter width too small");
   end

   assign wrap = adv && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (rst)
         cnt <= '0;
      else if (wrap)
         cnt <= '0;
      else if (adv)
         cnt <= cnt + 1'b1;
   end

   // R2 / R4: the count never leaves the period
   assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
      cnt <= LAST);
   // R4: the count moves only when advanced
   assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
      !adv |=> $stable(cnt));
endmodule

// File: rtl/mrt_window_decode.sv
module mrt_window_decode
   import mrt_pkg::*;
#(
   parameter int unsigned ACTIVE = 512,
   parameter int unsigned BLANK  = 192,
   parameter int unsigned FP     = 14,
   parameter int unsigned SYNC   = 178,
   parameter int unsigned CW     = $clog2(ACTIVE + BLANK)
) (
   input  logic [CW-1:0] cnt,
   output axis_strobe_t  strb
);
   localparam int unsigned TOTAL      = ACTIVE + BLANK;
   localparam int unsigned SYNC_START = ACTIVE + FP;
   localparam int unsigned SYNC_END   = SYNC_START + SYNC;
   localparam logic [CW-1:0] C_ACTIVE = CW'(ACTIVE);
   localparam logic [CW-1:0] C_START  = CW'(SYNC_START);

   initial begin
      assert (SYNC > 0) else $error("sync width must be nonzero");
      assert (SYNC_END <= TOTAL) else $error("porch and sync exceed blanking");
   end

   logic in_sync;

   generate
      if (SYNC_END >= TOTAL) begin : g_sync_to_end
         // sync runs to the end of the period: no back porch
         assign in_sync = (cnt >= C_START);
      end else begin : g_sync_window
         localparam logic [CW-1:0] C_END = CW'(SYNC_END);
         assign in_sync = (cnt >= C_START) && (cnt < C_END);
      end
   endgenerate

   assign strb.visible = (cnt < C_ACTIVE);
   assign strb.blank_n = (cnt < C_ACTIVE);
   assign strb.sync_n  = !in_sync;
endmodule

// File: rtl/mrt_addr_gen.sv
module mrt_addr_gen #(
   parameter int unsigned  ADDR_W   = 24,
   parameter logic [ADDR_W-1:0] BASE = 24'h9F9A80,
   parameter int unsigned  PIX_BYTE = 8,
   parameter int unsigned  GW       = $clog2(PIX_BYTE)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              pix_active,
   input  logic [GW-1:0]     dot_lsb,
   input  logic              frame_end,
   output logic [ADDR_W-1:0] addr
);
   initial begin
      assert ((1 << GW) == PIX_BYTE) else $error("pixels per byte must be a power of two");
   end

   logic byte_last;
   assign byte_last = (dot_lsb == {GW{1'b1}});

   always_ff @(posedge clk) begin
      if (rst || frame_end)
         addr <= BASE;
      else if (pix_active && byte_last)
         addr <= addr + 1'b1;
   end

   // R7: one step at the end of every visible pixel group
   assert_addr_step_R7: assert property (@(posedge clk) disable iff (rst)
      (pix_active && byte_last) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
   // R8: frozen outside visible video, apart from the frame wrap
   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (!pix_active && !frame_end) |=> $stable(addr));
   // R8: back to the base after the last dot of a frame
   assert_addr_wrap_R8: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> (addr == BASE));
endmodule

// File: rtl/mono_raster_timing.sv
module mono_raster_timing
   import mrt_pkg::*;
#(
   parameter int unsigned H_ACTIVE = DEF_H_ACTIVE,
   parameter int unsigned H_BLANK  = DEF_H_BLANK,
   parameter int unsigned H_FP     = DEF_H_FP,
   parameter int unsigned H_SYNC   = DEF_H_SYNC,
   parameter int unsigned V_ACTIVE = DEF_V_ACTIVE,
   parameter int unsigned V_BLANK  = DEF_V_BLANK,
   parameter int unsigned V_FP     = DEF_V_FP,
   parameter int unsigned V_SYNC   = DEF_V_SYNC,
   parameter int unsigned ADDR_W   = DEF_ADDR_W,
   parameter int unsigned PIX_BYTE = DEF_PIX_BYTE,
   parameter logic [ADDR_W-1:0] FB_BASE = 24'h9F9A80
) (
   input  logic              clk,
   input  logic              rst,
   output logic              hblank_n,
   output logic              hsync_n,
   output logic              vblank_n,
   output logic              vsync_n,
   output logic              active,
   output logic [ADDR_W-1:0] fb_addr,
   output logic              frame_irq
);
   localparam int unsigned H_TOTAL  = H_ACTIVE + H_BLANK;
   localparam int unsigned V_TOTAL  = V_ACTIVE + V_BLANK;
   localparam int unsigned HW       = $clog2(H_TOTAL);
   localparam int unsigned VW       = $clog2(V_TOTAL);
   localparam int unsigned GW       = $clog2(PIX_BYTE);
   localparam longint unsigned FB_BYTES = longint'(H_ACTIVE) * V_ACTIVE / PIX_BYTE;
   localparam logic [VW-1:0] V_IRQ_LINE = VW'(V_ACTIVE);

   initial begin
      assert (H_ACTIVE % PIX_BYTE == 0) else $error("line width not a whole number of bytes");
      assert (V_BLANK > 0) else $error("vertical blanking required for the frame pulse");
      assert (longint'(FB_BASE) + FB_BYTES <= (64'd1 << ADDR_W))
         else $error("frame buffer exceeds address width");
   end

   logic [HW-1:0] hcnt;
   logic [VW-1:0] vcnt;
   logic          h_wrap, v_wrap;
   axis_strobe_t  hs, vs;

   mrt_axis_counter #(.TOTAL(H_TOTAL), .CW(HW)) u_hcnt (
      .clk(clk), .rst(rst), .adv(1'b1), .cnt(hcnt), .wrap(h_wrap));

   mrt_axis_counter #(.TOTAL(V_TOTAL), .CW(VW)) u_vcnt (
      .clk(clk), .rst(rst), .adv(h_wrap), .cnt(vcnt), .wrap(v_wrap));

   mrt_window_decode #(.ACTIVE(H_ACTIVE), .BLANK(H_BLANK), .FP(H_FP),
      .SYNC(H_SYNC), .CW(HW)) u_hdec (.cnt(hcnt), .strb(hs));

   mrt_window_decode #(.ACTIVE(V_ACTIVE), .BLANK(V_BLANK), .FP(V_FP),
      .SYNC(V_SYNC), .CW(VW)) u_vdec (.cnt(vcnt), .strb(vs));

   assign active = hs.visible && vs.visible;

   mrt_addr_gen #(.ADDR_W(ADDR_W), .BASE(FB_BASE), .PIX_BYTE(PIX_BYTE),
      .GW(GW)) u_addr (
      .clk(clk), .rst(rst), .pix_active(active), .dot_lsb(hcnt[GW-1:0]),
      .frame_end(v_wrap), .addr(fb_addr));

   assign hblank_n  = hs.blank_n;
   assign hsync_n   = hs.sync_n;
   assign vblank_n  = vs.blank_n;
   assign vsync_n   = vs.sync_n;
   assign frame_irq = (vcnt == V_IRQ_LINE) && (hcnt == '0);

   // R3: horizontal sync lies inside horizontal blanking
   assert_hsync_in_blank_R3: assert property (@(posedge clk) disable iff (rst)
      !hsync_n |-> !hblank_n);
   // R5: vertical sync lies inside vertical blanking
   assert_vsync_in_blank_R5: assert property (@(posedge clk) disable iff (rst)
      !vsync_n |-> !vblank_n);
   // R9: the frame pulse is one clock wide
   assert_irq_single_R9: assert property (@(posedge clk) disable iff (rst)
      frame_irq |=> !frame_irq);
   // R9: entry into vertical blanking comes with the frame pulse
   assert_irq_at_vblank_R9: assert property (@(posedge clk) disable iff (rst)
      $fell(vblank_n) |-> frame_irq);
   // R6: no visible pixel during either blanking
   assert_active_R6: assert property (@(posedge clk) disable iff (rst)
      active |-> (vblank_n && hblank_n));
endmodule

// File: tb/tb_mono_raster_timing.sv
module tb_mono_raster_timing;
   logic clk = 1'b0;
   logic rst = 1'b1;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // default geometry instance
   logic d_hb, d_hs, d_vb, d_vs, d_act, d_irq;
   logic [23:0] d_addr;
   mono_raster_timing dut (
      .clk(clk), .rst(rst), .hblank_n(d_hb), .hsync_n(d_hs), .vblank_n(d_vb),
      .vsync_n(d_vs), .active(d_act), .fb_addr(d_addr), .frame_irq(d_irq));

   // reduced geometry instance, full frames fit in the run
   localparam int SHA = 32, SHB = 16, SHF = 4, SHS = 6;
   localparam int SVA = 6,  SVB = 5,  SVF = 0, SVS = 2;
   localparam int SBASE = 24'h001000;
   logic s_hb, s_hs, s_vb, s_vs, s_act, s_irq;
   logic [23:0] s_addr;
   mono_raster_timing #(
      .H_ACTIVE(SHA), .H_BLANK(SHB), .H_FP(SHF), .H_SYNC(SHS),
      .V_ACTIVE(SVA), .V_BLANK(SVB), .V_FP(SVF), .V_SYNC(SVS),
      .FB_BASE(24'h001000)) dut_small (
      .clk(clk), .rst(rst), .hblank_n(s_hb), .hsync_n(s_hs), .vblank_n(s_vb),
      .vsync_n(s_vs), .active(s_act), .fb_addr(s_addr), .frame_irq(s_irq));

   int dh, dv, sh, sv;
   bit first;

   task automatic chk(input string req, input string what, input int h, input int v,
                      input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s dot=%0d line=%0d got %0h expected %0h", req, what, h, v, got, exp);
      end
   endtask

   task automatic cmp(input string nm, input int h, input int v,
                      input int ha, input int hf, input int hsy,
                      input int va, input int vf, input int vsy, input int base,
                      input logic hb, input logic hs, input logic vb, input logic vs,
                      input logic act, input logic irq, input logic [23:0] ad);
      int bpl = ha / 8;
      longint ea;
      bit e_act = (h < ha) && (v < va);
      if (v >= va)     ea = base + va * bpl;
      else if (h < ha) ea = base + v * bpl + h / 8;
      else             ea = base + (v + 1) * bpl;
      chk(first ? "R1" : "R2", {nm, " hblank_n"}, h, v, hb, h < ha);
      chk(first ? "R1" : "R3", {nm, " hsync_n"}, h, v, hs,
          !((h >= ha + hf) && (h < ha + hf + hsy)));
      chk(first ? "R1" : "R4", {nm, " vblank_n"}, h, v, vb, v < va);
      chk(first ? "R1" : "R5", {nm, " vsync_n"}, h, v, vs,
          !((v >= va + vf) && (v < va + vf + vsy)));
      chk(first ? "R1" : "R6", {nm, " active"}, h, v, act, e_act);
      chk(first ? "R1" : (e_act ? "R7" : "R8"), {nm, " fb_addr"}, h, v, ad, ea);
      chk(first ? "R1" : "R9", {nm, " frame_irq"}, h, v, irq, (v == va) && (h == 0));
   endtask

   task automatic step_models();
      dh++;
      if (dh == 512 + 192) begin dh = 0; dv++; if (dv == 370) dv = 0; end
      sh++;
      if (sh == SHA + SHB) begin sh = 0; sv++; if (sv == SVA + SVB) sv = 0; end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         cmp("default", dh, dv, 512, 14, 178, 342, 0, 4, 24'h9F9A80,
             d_hb, d_hs, d_vb, d_vs, d_act, d_irq, d_addr);
         cmp("small", sh, sv, SHA, SHF, SHS, SVA, SVF, SVS, SBASE,
             s_hb, s_hs, s_vb, s_vs, s_act, s_irq, s_addr);
         first = 1'b0;
         step_models();
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      dh = 0; dv = 0; sh = 0; sv = 0; first = 1'b1;
      // R1 reset state, R2/R3/R7 over three default lines,
      // R4/R5/R8/R9 over several reduced frames
      run(2600);
      // R1: reset in the middle of a line
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      dh = 0; dv = 0; sh = 0; sv = 0; first = 1'b1;
      run(1200);
      finish_run();
   end
endmodule